// File: doc/BRIEF.md
# Dual-Port Shared Array Arbiter

This block sits between two serial-bus slave front ends and the single 1024-byte storage array they share. One front end faces the display controller and the other faces the host's display data channel. Each front end holds its request line high from the start condition to the stop condition of any transaction that addresses the device. The arbiter gives the array to exactly one port at a time. A port that asks while the other owns the array has its clock line held low through an open-drain hold output. The stalled port simply waits, so neither side can tell that the memory is shared.

When a transaction that wrote data ends, the owning front end reports the write with its write flag. The arbiter then starts a self-timed program window. For the length of that window it refuses both ports: no grant is given, no clock is held, and the no-acknowledge output tells both front ends to leave their slave address unacknowledged. After reset a power-up counter holds off read access and write access for separate numbers of cycles. Ties between the ports go to the display side.

Top module: `dual_port_arbiter`

## Requirements
- R1: While reset is asserted, and at the first sample after it, both grants and both hold outputs are low, and rdReady and wrReady are low.
- R2: At no time are dispGrant and hostGrant high together.
- R3: A lone request that is seen at a clock edge while the array is free and noAck is low raises that port's grant at that edge. The grant stays high for as long as the request stays high.
- R4: When both requests are first seen at the same edge on a free array, the display port is granted and the host port's hold output goes high.
- R5: A request that arrives while the other port owns the array raises the requester's hold output at the next edge, and the hold stays high while the owner keeps its request.
- R6: When the owner drops its request with its write flag low and the other port is waiting, the same edge lowers the old grant, raises the waiting port's grant and lowers its hold output.
- R7: When the owner drops its request with its write flag high, noAck rises at that edge and stays high for exactly WR_CYC samples. At that same edge the waiting port's hold output is released.
- R8: While noAck is high, requests from either port are refused: no grant rises and no hold output rises.
- R9: rdReady first reads high PU_RD_CYC clock edges after reset is released, and wrReady first reads high PU_WR_CYC edges after. Until rdReady is high, noAck is high and no grant is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispReq | input | 1 | Display-side transaction in progress (start to stop) |
| dispWr | input | 1 | Display transaction wrote data; sampled when dispReq falls |
| hostReq | input | 1 | Host-side transaction in progress (start to stop) |
| hostWr | input | 1 | Host transaction wrote data; sampled when hostReq falls |
| dispGrant | output | 1 | Array owned by the display port |
| hostGrant | output | 1 | Array owned by the host port |
| dispSclHold | output | 1 | Drive the display clock line low (open-drain) |
| hostSclHold | output | 1 | Drive the host clock line low (open-drain) |
| noAck | output | 1 | Both front ends must not acknowledge their address |
| rdReady | output | 1 | Power-up read delay has elapsed |
| wrReady | output | 1 | Power-up write delay has elapsed |

## Verification
A wrong owner state shows up at the grant and hold pins on the very next edge. Two grants together, a hold that outlives its rival's grant, or a waiting port that is never handed the array are all visible one sample after the fault. A corrupted program-window counter changes how long noAck stays high, so the bench counts the busy samples exactly instead of only waiting for noAck to fall. A faulty power-up counter moves the first high sample of rdReady or wrReady away from its exact expected edge.

// File: rtl/dual_port_arbiter_pkg.sv
package dual_port_arbiter_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DISP = 2'd1,
    OWN_HOST = 2'd2
  } owner_t;

  // strobes from the control to the timer datapath
  typedef struct packed {
    logic loadBusy;   // a write transaction has just ended
  } ctrlStrobes_t;

endpackage

// File: rtl/arb_timers.sv
module arb_timers
  import dual_port_arbiter_pkg::*;
#(
  parameter int PU_RD_CYC = 20,
  parameter int PU_WR_CYC = 40,
  parameter int WR_CYC    = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         noAck,
  output logic         rdReady,
  output logic         wrReady
);

  localparam int PU_MAX = (PU_RD_CYC > PU_WR_CYC) ? PU_RD_CYC : PU_WR_CYC;
  localparam int PU_W   = $clog2(PU_MAX + 1);
  localparam int WR_W   = $clog2(WR_CYC + 1);

  logic [PU_W-1:0] puCnt;
  logic [WR_W-1:0] busyCnt;
  logic            busy;

  // power-up counter, saturates at the longer of the two delays
  always_ff @(posedge clk) begin
    if (!rstN)                      puCnt <= '0;
    else if (puCnt != PU_W'(PU_MAX)) puCnt <= puCnt + 1'b1;
  end

  // self-timed program window, counts down to zero
  always_ff @(posedge clk) begin
    if (!rstN)                 busyCnt <= '0;
    else if (strobes.loadBusy) busyCnt <= WR_W'(WR_CYC);
    else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
  end

  assign busy    = (busyCnt != '0);
  assign rdReady = (puCnt >= PU_W'(PU_RD_CYC));
  assign wrReady = (puCnt >= PU_W'(PU_WR_CYC));
  assign noAck   = busy || !rdReady;

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBusy |=> noAck);

  p_busy_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0 && !strobes.loadBusy) |=> (busyCnt == $past(busyCnt) - 1'b1));

  p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> rdReady);

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import dual_port_arbiter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         dispReq,
  input  logic         dispWr,
  input  logic         hostReq,
  input  logic         hostWr,
  input  logic         noAck,
  output ctrlStrobes_t strobes,
  output logic         dispGrant,
  output logic         hostGrant,
  output logic         dispSclHold,
  output logic         hostSclHold
);

  owner_t owner, nextOwner;
  logic   keepOwner;
  logic   blocked;

  always_comb begin
    keepOwner = (owner == OWN_DISP && dispReq) || (owner == OWN_HOST && hostReq);
    strobes.loadBusy = (owner == OWN_DISP && !dispReq && dispWr) ||
                       (owner == OWN_HOST && !hostReq && hostWr);
    blocked = noAck || strobes.loadBusy;
    if (keepOwner)    nextOwner = owner;
    else if (blocked) nextOwner = OWN_NONE;
    else if (dispReq) nextOwner = OWN_DISP;   // fixed priority on ties
    else if (hostReq) nextOwner = OWN_HOST;
    else              nextOwner = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner       <= OWN_NONE;
      dispSclHold <= 1'b0;
      hostSclHold <= 1'b0;
    end else begin
      owner       <= nextOwner;
      dispSclHold <= dispReq && (nextOwner == OWN_HOST);
      hostSclHold <= hostReq && (nextOwner == OWN_DISP);
    end
  end

  assign dispGrant = (owner == OWN_DISP);
  assign hostGrant = (owner == OWN_HOST);

  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(dispGrant && hostGrant));

  p_disp_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE && dispReq && hostReq && !noAck) |=> dispGrant);

  p_hold_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostGrant) |-> !dispSclHold);

  p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (noAck && owner == OWN_NONE) |=> (owner == OWN_NONE && !dispSclHold && !hostSclHold));

endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dual_port_arbiter_pkg::*;
#(
  parameter int PU_RD_CYC = 20,
  parameter int PU_WR_CYC = 40,
  parameter int WR_CYC    = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic dispReq,
  input  logic dispWr,
  input  logic hostReq,
  input  logic hostWr,
  output logic dispGrant,
  output logic hostGrant,
  output logic dispSclHold,
  output logic hostSclHold,
  output logic noAck,
  output logic rdReady,
  output logic wrReady
);

  ctrlStrobes_t strobes;

  arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .dispReq(dispReq), .dispWr(dispWr),
    .hostReq(hostReq), .hostWr(hostWr),
    .noAck(noAck), .strobes(strobes),
    .dispGrant(dispGrant), .hostGrant(hostGrant),
    .dispSclHold(dispSclHold), .hostSclHold(hostSclHold)
  );

  arb_timers #(
    .PU_RD_CYC(PU_RD_CYC), .PU_WR_CYC(PU_WR_CYC), .WR_CYC(WR_CYC)
  ) timers_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .noAck(noAck), .rdReady(rdReady), .wrReady(wrReady)
  );

endmodule

// File: tb/dual_port_arbiter_tb_top.sv
module dual_port_arbiter_tb_top;

  localparam int PU_RD = 20;
  localparam int PU_WR = 40;
  localparam int WRC   = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispReq = 1'b0, dispWr = 1'b0, hostReq = 1'b0, hostWr = 1'b0;
  logic dispGrant, hostGrant, dispSclHold, hostSclHold, noAck, rdReady, wrReady;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;   // 250 MHz

  dual_port_arbiter #(.PU_RD_CYC(PU_RD), .PU_WR_CYC(PU_WR), .WR_CYC(WRC)) dut_i (
    .clk(clk), .rstN(rstN),
    .dispReq(dispReq), .dispWr(dispWr), .hostReq(hostReq), .hostWr(hostWr),
    .dispGrant(dispGrant), .hostGrant(hostGrant),
    .dispSclHold(dispSclHold), .hostSclHold(hostSclHold),
    .noAck(noAck), .rdReady(rdReady), .wrReady(wrReady)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    tick(); tick();
    chk("R1 grants in reset", {dispGrant, hostGrant}, 0);
    chk("R1 holds in reset", {dispSclHold, hostSclHold}, 0);
    chk("R1 ready in reset", {rdReady, wrReady}, 0);
    rstN = 1'b1;
    chk("R1 first sample grants", {dispGrant, hostGrant}, 0);
  endtask

  task automatic testPowerUp();
    int n = 0;
    int gseen = 0;
    dispReq = 1'b1;
    while (!rdReady && n < 500) begin
      tick(); n++;
      if (!rdReady) begin
        if (dispGrant) gseen++;
        chk("R9 noAck before ready", noAck, 1);
      end
    end
    chk("R9 read delay", n, PU_RD);
    chk("R9 no grant before ready", gseen, 0);
    dispReq = 1'b0;
    while (!wrReady && n < 500) begin tick(); n++; end
    chk("R9 write delay", n, PU_WR);
    tick();
  endtask

  task automatic testSingle();
    hostReq = 1'b1; tick();
    chk("R3 lone host granted", hostGrant, 1);
    chk("R2 lone host exclusive", dispGrant, 0);
    tick(); tick();
    chk("R3 grant held", hostGrant, 1);
    hostReq = 1'b0; tick();
    chk("R3 grant released", hostGrant, 0);
    chk("R3 no busy on read", noAck, 0);
  endtask

  task automatic testContention();
    hostReq = 1'b1; tick();
    dispReq = 1'b1; tick();
    chk("R5 display held", dispSclHold, 1);
    chk("R5 display not granted", dispGrant, 0);
    tick();
    chk("R5 hold persists", dispSclHold, 1);
    hostReq = 1'b0; tick();
    chk("R6 host released", hostGrant, 0);
    chk("R6 display handed over", dispGrant, 1);
    chk("R6 display hold dropped", dispSclHold, 0);
    dispReq = 1'b0; tick();
    chk("R6 idle after", {dispGrant, hostGrant}, 0);
  endtask

  task automatic testTieAndWrite();
    int n = 0;
    int leak = 0;
    dispReq = 1'b1; hostReq = 1'b1; tick();
    chk("R4 display wins tie", dispGrant, 1);
    chk("R4 host held on tie", hostSclHold, 1);
    chk("R2 tie exclusive", hostGrant, 0);
    dispWr = 1'b1; dispReq = 1'b0; tick();
    dispWr = 1'b0;
    chk("R7 noAck on write stop", noAck, 1);
    chk("R7 waiting hold released", hostSclHold, 0);
    while (noAck && n < 500) begin
      n++;
      if (hostGrant || dispGrant || hostSclHold) leak++;
      tick();
    end
    chk("R7 busy length", n, WRC);
    chk("R8 refused while busy", leak, 0);
    tick();
    chk("R8 host granted after busy", hostGrant, 1);
    hostReq = 1'b0; tick();
    chk("R3 end idle", {dispGrant, hostGrant, dispSclHold, hostSclHold}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    testReset();
    testPowerUp();
    testSingle();
    testContention();
    testTieAndWrite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule